// File: doc/BRIEF.md
# Clock-Generator Configuration Slave (Two-Wire Block Access)

This block is a two-wire serial (I2C) slave that stores six 8-bit configuration bytes for a clock generator. The host writes them with a block write. After the device address it sends two bytes that must be present but whose values are thrown away. It then sends data bytes, which land in byte 0, byte 1 and upward until a STOP. The host reads the bytes back with a block read. The slave first answers with a byte count and then returns byte 0 upward until the host stops.

Both bus lines are sampled by a system clock that is much faster than the bus. The slave drives SDA only by pulling it low, which is modelled as an output enable. All configuration bytes are visible in parallel on one flat output vector. SDA goes low whenever `sda_oe` is 1.

Top module: `i2c_cfg_slave`

## Requirements
- R1: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A STOP ends any transfer and releases SDA.
- R2: The slave acknowledges the address byte 0xD2 (write) and the address byte 0xD3 (read). To acknowledge, it holds SDA low during the ninth clock of the byte. Bytes are shifted MSB first.
- R3: On a write, the two bytes after the address are acknowledged and their values are discarded.
- R4: On a write, the later data bytes go in order into byte 0, byte 1 and upward. Byte k appears on `cfg_regs[8k+7:8k]`.
- R5: A write may end with a STOP after any complete byte. Bytes written before the STOP keep their new values, and the other bytes are unchanged.
- R6: After reset, byte 0 is 0x00 and bytes 1 to 5 are 0xFF.
- R7: On a read, the slave sends the count 0x06 first and then byte 0, byte 1 and upward. It continues while the host acknowledges (SDA low). After a host not-acknowledge (SDA high), it releases SDA.
- R8: The slave starts pulling SDA low only while SCL is low.
- R9: Write data beyond byte 5 is acknowledged and has no effect. A read beyond byte 5 returns 0xFF.
- R10: After an address byte that does not match, the slave does not acknowledge and ignores the bus until the next START. Bytes sent in that state get no acknowledge and change no register.
- R11: A repeated START ends the current transfer and begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| cfg_regs | output | 48 | Configuration bytes, byte k at bits 8k+7:8k |

## Verification
The bench targets the places where byte counting can go wrong:
- **Discarded header bytes.** A design that stored the two header bytes would shift every data byte up two places.
- **Writes past the last byte.** A design without a bound would alias these writes into byte 0 or refuse the acknowledge.
- **Reads past the last byte.** These should return 0xFF; a design without the bound would return stale or wrapped data.
- **Short writes.** A write that stops after one data byte must leave bytes 1 and up untouched.
- **Unmatched address.** A slave that kept listening after an unmatched address would acknowledge or store the bytes that follow it.
- **Repeated START after an unmatched address.** A slave that waited for a STOP would miss the new write.
- **Repeated START from write into read.** A slave that kept its write position would lose the read count.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_WR,
    ST_RD,
    ST_RDACK,
    ST_IGNORE
  } i2c_state_e;

  localparam logic [6:0] DEV_ADDR_DEFAULT = 7'h69;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_p    <= 1'b1;
      sda_p    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
      scl_p    <= scl_pipe[SYNC_STAGES-1];
      sda_p    <= sda_pipe[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[SYNC_STAGES-1];
  assign sda_s     = sda_pipe[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile #(
  parameter int         NUM_REGS  = 6,
  parameter int         CNT_W     = 4,
  parameter logic [7:0] RST_FIRST = 8'h00,
  parameter logic [7:0] RST_REST  = 8'hFF
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [CNT_W-1:0]      wr_idx,
  input  logic [7:0]            wr_data,
  input  logic [CNT_W-1:0]      rd_idx,
  output logic [7:0]            rd_data,
  output logic [NUM_REGS*8-1:0] regs_o
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [7:0] mem [NUM_REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++)
        mem[i] <= (i == 0) ? RST_FIRST : RST_REST;
    end else if (wr_en && (wr_idx < CNT_W'(NUM_REGS))) begin
      mem[wr_idx[IDX_W-1:0]] <= wr_data;
    end
  end

  always_comb begin
    if (rd_idx < CNT_W'(NUM_REGS)) rd_data = mem[rd_idx[IDX_W-1:0]];
    else                           rd_data = 8'hFF;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign regs_o[8*g +: 8] = mem[g];
  end

  // R9: a write aimed past the last byte leaves every byte unchanged
  a_r9_oob_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_idx >= CNT_W'(NUM_REGS))) |=> $stable(regs_o));
endmodule

// File: rtl/i2c_cfg_engine.sv
module i2c_cfg_engine
  import i2c_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = DEV_ADDR_DEFAULT,
  parameter int         NUM_REGS = 6,
  parameter int         CNT_W    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_s,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [7:0]       rd_data,
  output logic [CNT_W-1:0] rd_idx,
  output logic             wr_en,
  output logic [CNT_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic             sda_oe
);
  localparam logic [CNT_W-1:0] HDR_BYTES = CNT_W'(2);

  i2c_state_e       state;
  logic [3:0]       bitcnt;
  logic [7:0]       rx_sh, tx_sh;
  logic [CNT_W-1:0] bcnt;
  logic             rw, host_nack;
  logic [7:0]       next_tx;

  assign rd_idx  = bcnt - CNT_W'(1);
  assign next_tx = (bcnt == '0) ? 8'(NUM_REGS) : rd_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bitcnt    <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      bcnt      <= '0;
      rw        <= 1'b0;
      host_nack <= 1'b0;
      sda_oe    <= 1'b0;
      wr_en     <= 1'b0;
      wr_idx    <= '0;
      wr_data   <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state  <= ST_ADDR;
        bitcnt <= '0;
        bcnt   <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR: begin
            if (scl_rise) begin
              rx_sh  <= {rx_sh[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              if (rx_sh[7:1] == DEV_ADDR) begin
                rw     <= rx_sh[0];
                sda_oe <= 1'b1;
                state  <= ST_ACK;
              end else begin
                state  <= ST_IGNORE;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (rw) begin
                state  <= ST_RD;
                tx_sh  <= next_tx;
                sda_oe <= ~next_tx[7];
              end else begin
                state  <= ST_WR;
                sda_oe <= 1'b0;
              end
            end
          end
          ST_WR: begin
            if (scl_rise) begin
              rx_sh  <= {rx_sh[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              sda_oe <= 1'b1;
              state  <= ST_ACK;
              if (bcnt >= HDR_BYTES) begin
                wr_en   <= 1'b1;
                wr_idx  <= bcnt - HDR_BYTES;
                wr_data <= rx_sh;
              end
              if (bcnt != '1) bcnt <= bcnt + CNT_W'(1);
            end
          end
          ST_RD: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_oe <= 1'b0;
                state  <= ST_RDACK;
                if (bcnt != '1) bcnt <= bcnt + CNT_W'(1);
              end else begin
                sda_oe <= ~tx_sh[6];
                tx_sh  <= {tx_sh[6:0], 1'b1};
              end
            end
          end
          ST_RDACK: begin
            if (scl_rise) begin
              host_nack <= sda_s;
            end else if (scl_fall) begin
              bitcnt <= '0;
              if (host_nack) begin
                state <= ST_IGNORE;
              end else begin
                state  <= ST_RD;
                tx_sh  <= next_tx;
                sda_oe <= ~next_tx[7];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R1: after a STOP the slave is idle with SDA released
  a_r1_stop_releases: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (state == ST_IDLE && !sda_oe));
  // R11: a START, repeated or not, reopens the address phase
  a_r11_start_rearms: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (state == ST_ADDR && !sda_oe));
  // R8: the slave begins pulling SDA low only while SCL is low
  a_r8_pull_on_scl_low: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_s);
  // R10: an ignored transfer never drives the bus
  a_r10_ignore_silent: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IGNORE) |-> !sda_oe);
endmodule

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave
  import i2c_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = DEV_ADDR_DEFAULT,
  parameter int         NUM_REGS    = 6,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  output logic [NUM_REGS*8-1:0] cfg_regs
);
  localparam int CNT_W = $clog2(NUM_REGS + 3) + 1;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic             wr_en;
  logic [CNT_W-1:0] wr_idx, rd_idx;
  logic [7:0]       wr_data, rd_data;

  i2c_line_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filter (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_cfg_engine #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS), .CNT_W(CNT_W)) u_engine (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .rd_idx(rd_idx),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .sda_oe(sda_oe)
  );

  cfg_regfile #(.NUM_REGS(NUM_REGS), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .regs_o(cfg_regs)
  );
endmodule

// File: tb/tb_i2c_cfg_slave.sv
module tb_i2c_cfg_slave;
  localparam int Q = 25;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda_low = 1'b0;
  logic sda_oe;
  logic sda_line;
  logic [47:0] cfg_regs;

  always #2 clk = ~clk;
  assign sda_line = ~(m_sda_low | sda_oe);

  i2c_cfg_slave dut (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .cfg_regs(cfg_regs)
  );

  string      req_q[$];
  logic [7:0] exp_q[$];
  logic [7:0] act_q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // monitor: pops observed items and compares against the expected queue
  initial begin
    forever begin
      @(negedge clk);
      while (act_q.size() > 0 && exp_q.size() > 0) begin
        automatic string      r = req_q.pop_front();
        automatic logic [7:0] e = exp_q.pop_front();
        automatic logic [7:0] a = act_q.pop_front();
        n_chk++;
        if (a !== e) begin
          n_bad++;
          $display("FAIL %s: actual %02h expected %02h", r, a, e);
        end
      end
    end
  end

  task automatic expect_v(input string r, input logic [7:0] v);
    req_q.push_back(r);
    exp_q.push_back(v);
  endtask

  task automatic q_wait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda_low = 1'b0; q_wait();
    m_scl = 1'b1;     q_wait();
    m_sda_low = 1'b1; q_wait();
    m_scl = 1'b0;     q_wait();
  endtask

  task automatic bus_stop();
    m_sda_low = 1'b1; q_wait();
    m_scl = 1'b1;     q_wait();
    m_sda_low = 1'b0; q_wait(); q_wait();
  endtask

  task automatic bit_out(input logic b);
    m_sda_low = ~b; q_wait();
    m_scl = 1'b1;   q_wait(); q_wait();
    m_scl = 1'b0;   q_wait();
  endtask

  task automatic bit_in(output logic b);
    m_sda_low = 1'b0; q_wait();
    m_scl = 1'b1;     q_wait();
    b = sda_line;     q_wait();
    m_scl = 1'b0;     q_wait();
  endtask

  // write a byte; expected ack (1 = acknowledged) pushed, observed ack pushed
  task automatic wr(input logic [7:0] v, input logic exp_ack, input string r);
    logic a;
    expect_v(r, {7'd0, exp_ack});
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
    bit_in(a);
    act_q.push_back({7'd0, ~a});
  endtask

  task automatic rd(input logic [7:0] e, input logic host_ack, input string r);
    logic [7:0] v;
    logic b;
    expect_v(r, e);
    for (int i = 7; i >= 0; i--) begin
      bit_in(b);
      v[i] = b;
    end
    bit_out(~host_ack);
    act_q.push_back(v);
  endtask

  task automatic chk_regs(input logic [7:0] e [6], input string r);
    for (int k = 0; k < 6; k++) begin
      expect_v(r, e[k]);
      act_q.push_back(cfg_regs[8*k +: 8]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] e [6];
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);

    // R6: reset values
    e = '{8'h00, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    chk_regs(e, "R6 reset value");
    expect_v("R6 sda released after reset", 8'h00);
    act_q.push_back({7'd0, sda_oe});

    // R2 R3 R4: header discarded, data from byte 0 upward
    bus_start();
    wr(8'hD2, 1'b1, "R2 write address ack");
    wr(8'h55, 1'b1, "R3 command byte ack");
    wr(8'h99, 1'b1, "R3 count byte ack");
    wr(8'hA1, 1'b1, "R4 data ack");
    wr(8'hB2, 1'b1, "R4 data ack");
    wr(8'hC3, 1'b1, "R4 data ack");
    bus_stop();
    e = '{8'hA1, 8'hB2, 8'hC3, 8'hFF, 8'hFF, 8'hFF};
    chk_regs(e, "R4 sequential load");
    expect_v("R1 sda released after stop", 8'h00);
    act_q.push_back({7'd0, sda_oe});

    // R5: short write after one data byte
    bus_start();
    wr(8'hD2, 1'b1, "R5 address ack");
    wr(8'h00, 1'b1, "R5 header");
    wr(8'h00, 1'b1, "R5 header");
    wr(8'h3C, 1'b1, "R5 data ack");
    bus_stop();
    e = '{8'h3C, 8'hB2, 8'hC3, 8'hFF, 8'hFF, 8'hFF};
    chk_regs(e, "R5 partial write");

    // R9: eight data bytes, the last two acknowledged but dropped
    bus_start();
    wr(8'hD2, 1'b1, "R9 address ack");
    wr(8'hEE, 1'b1, "R3 header");
    wr(8'h01, 1'b1, "R3 header");
    for (int i = 0; i < 8; i++)
      wr(8'h10 + 8'(i), 1'b1, (i < 6) ? "R4 data ack" : "R9 excess write ack");
    bus_stop();
    e = '{8'h10, 8'h11, 8'h12, 8'h13, 8'h14, 8'h15};
    chk_regs(e, "R9 excess write ignored");

    // R7 R9: block read with count, then read past the end
    bus_start();
    wr(8'hD3, 1'b1, "R2 read address ack");
    rd(8'h06, 1'b1, "R7 byte count");
    for (int i = 0; i < 6; i++) rd(8'h10 + 8'(i), 1'b1, "R7 readback");
    rd(8'hFF, 1'b0, "R9 read past end");
    bus_stop();
    expect_v("R7 released after host nack", 8'h00);
    act_q.push_back({7'd0, sda_oe});

    // R10: unmatched address, following bytes ignored
    bus_start();
    wr(8'hA0, 1'b0, "R10 unmatched address nack");
    wr(8'hD2, 1'b0, "R10 ignored byte nack");
    wr(8'h00, 1'b0, "R10 ignored byte nack");
    wr(8'h77, 1'b0, "R10 ignored byte nack");
    bus_stop();
    chk_regs(e, "R10 registers untouched");

    // R11: repeated START after unmatched address, then write, then read
    bus_start();
    wr(8'hA6, 1'b0, "R10 unmatched address nack");
    bus_start();
    wr(8'hD2, 1'b1, "R11 address after repeated start");
    wr(8'h00, 1'b1, "R3 header");
    wr(8'h00, 1'b1, "R3 header");
    wr(8'h5A, 1'b1, "R11 data ack");
    bus_start();
    wr(8'hD3, 1'b1, "R11 read address after repeated start");
    rd(8'h06, 1'b1, "R11 count restarts");
    rd(8'h5A, 1'b0, "R11 byte 0 readback");
    bus_stop();
    e = '{8'h5A, 8'h11, 8'h12, 8'h13, 8'h14, 8'h15};
    chk_regs(e, "R11 final registers");

    repeat (10) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule